// File: doc/BRIEF.md
# Register-Mapped GPIO Expander Core

This block holds the register bank and pin logic of a 24-pin general-purpose I/O expander. Pins 0 to 15 form the main set and pins 16 to 23 form the alternate set. Each set has its own enable bit. A byte-wide register port carries all access: address, write data, write strobe, read strobe and registered read data. A "first" qualifier loads the address. Strobes that follow without it go on from an internal pointer that steps by one after every byte, so a burst can walk consecutive registers.

Every pin has a direction bit, a drive-type bit, a bias bit and an output latch. The output latch is never written directly. It changes only through separate set-mask and clear-mask registers. Input levels pass through a two-flop synchroniser before they reach a readable state register. An identity register reports the complement of the 8-bit bus address, which depends on an address strap. A system control byte enables each pin set and can request a soft reset. The soft reset clears every setting and keeps the block busy for a window whose length is a parameter. During that window writes have no effect.

Top module: `gpx_core`

## Requirements
- R1: After `rst`, every pin is an input: `pin_oe`, `pin_out`, `pin_pu` and `pin_pd` are all zero, `busy` is 0, `reg_rdata` is 0, and both pin sets are disabled.
- R2: A read of address 0x00 returns the bitwise complement of {seven-bit bus address, 0}. The seven-bit address is 0x42 with the strap in bit 0, so it reads 0x7B with `addr_strap`=0 and 0x79 with `addr_strap`=1.
- R3: Address 0x01 holds the major version and 0x02 the minor version. A strobe with `reg_first`=0 uses the previous access address plus one, so a two-byte read burst that starts at 0x01 returns major and then minor.
- R4: System control sits at 0x40. Bit 0 enables pins 0-15 and bit 3 enables pins 16-23. A read returns those two bits and 0 in every other position.
- R5: Direction bytes sit at 0x60-0x62. Pin n uses byte base+n/8, bit n%8. A 1 makes the pin an output. An enabled push-pull output has `pin_oe`=1 and `pin_out` equal to its latch. `pin_out` is never 1 while `pin_oe` is 0.
- R6: A write to set bytes 0x6C-0x6E sets the latch of every pin whose bit is 1. A write to clear bytes 0x70-0x72 clears them. Pins whose bit is 0 keep their latch. A read of either byte returns the latch.
- R7: Type bytes sit at 0x64-0x66 and bias bytes at 0x68-0x6A. Type 0 means push-pull with no bias. An enabled input with type 1 gets `pin_pu` when its bias bit is 1 and `pin_pd` when it is 0. Outputs never get a pull.
- R8: An enabled output with type 1 is open-drain. It has `pin_oe`=1 only while its latch is 0, and `pin_out` stays 0.
- R9: State bytes 0x10-0x12 report the pin input levels. A level change is readable three clock edges after it appears on `pin_in`. Pins of a disabled set read 0.
- R10: Every pin of a disabled set has `pin_oe`, `pin_out`, `pin_pu` and `pin_pd` at 0.
- R11: A write of a byte with bit 7 set to 0x40 clears direction, type, bias, latch and both enables. `busy` is then 1 for exactly RST_CYCLES cycles, starting on the next cycle. Writes during that window are ignored, reads still work, and bit 7 always reads 0.
- R12: Reads of unmapped addresses return 0. Writes to unmapped or read-only addresses (0x00-0x02, 0x10-0x12, 0x63) change nothing.
- R13: `reg_rdata` updates on the clock edge after a `reg_rd` strobe and holds between reads. When `reg_wr` and `reg_rd` are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 1 | Bus address strap (bit 0 of the seven-bit address) |
| reg_addr | input | 8 | Register address, used when reg_first is 1 |
| reg_first | input | 1 | Load reg_addr for this strobe; otherwise use the burst pointer |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Pin input levels (asynchronous) |
| pin_oe | output | 24 | Per-pin output enable |
| pin_out | output | 24 | Per-pin output value |
| pin_pu | output | 24 | Per-pin pull-up enable |
| pin_pd | output | 24 | Per-pin pull-down enable |
| busy | output | 1 | Soft-reset window active |

## Verification
The pad outputs are tried with direction masks that differ in every byte, so a wrong byte or bit mapping in the pin-to-register arithmetic is exposed. Set and clear masks that overlap earlier latch contents show whether untouched bits keep their value. Mixed type and bias masks cover push-pull, open-drain, pull-up and pull-down in a single group, which separates input pins from output pins. A distinct input pattern in each byte, read back while one set is disabled, tests the synchroniser delay and the masking of disabled pins. The soft-reset window is timed to the cycle, with writes and reads issued inside it.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int GRP_W    = 8;
    localparam int NUM_GRP  = 3;
    localparam int MAIN_GRP = 2;
    localparam int PIN_N    = GRP_W * NUM_GRP;
    localparam int GSEL_W   = 2;
    localparam logic [7:0] NUM_GRP_B = 8'(NUM_GRP);

    // register map
    localparam logic [7:0] A_IDENT = 8'h00;
    localparam logic [7:0] A_VMAJ  = 8'h01;
    localparam logic [7:0] A_VMIN  = 8'h02;
    localparam logic [7:0] A_SYS   = 8'h40;
    localparam logic [7:0] A_STATE = 8'h10;
    localparam logic [7:0] A_DIR   = 8'h60;
    localparam logic [7:0] A_TYPE  = 8'h64;
    localparam logic [7:0] A_BIAS  = 8'h68;
    localparam logic [7:0] A_SET   = 8'h6C;
    localparam logic [7:0] A_CLR   = 8'h70;

    localparam int SYS_MAIN_BIT = 0;
    localparam int SYS_ALT_BIT  = 3;
    localparam int SYS_RST_BIT  = 7;

    typedef enum logic [3:0] {
        FN_NONE, FN_IDENT, FN_VMAJ, FN_VMIN, FN_SYS, FN_STATE,
        FN_DIR, FN_TYPE, FN_BIAS, FN_SET, FN_CLR
    } gpx_fn_e;

    typedef struct packed {
        gpx_fn_e             fn;
        logic [GSEL_W-1:0]   grp;
    } gpx_dec_t;

    typedef struct packed {
        logic       wr;
        logic       rd;
        gpx_dec_t   dec;
        logic [7:0] data;
    } gpx_acc_t;

    function automatic logic gpx_in_bank(input logic [7:0] a, input logic [7:0] base);
        return (a >= base) && ((a - base) < NUM_GRP_B);
    endfunction

    function automatic gpx_dec_t gpx_decode(input logic [7:0] a);
        gpx_dec_t   d;
        logic [7:0] off;
        d.fn = FN_NONE;
        off  = '0;
        case (a)
            A_IDENT: d.fn = FN_IDENT;
            A_VMAJ:  d.fn = FN_VMAJ;
            A_VMIN:  d.fn = FN_VMIN;
            A_SYS:   d.fn = FN_SYS;
            default: begin
                if (gpx_in_bank(a, A_STATE)) begin
                    d.fn = FN_STATE; off = a - A_STATE;
                end else if (gpx_in_bank(a, A_DIR)) begin
                    d.fn = FN_DIR;   off = a - A_DIR;
                end else if (gpx_in_bank(a, A_TYPE)) begin
                    d.fn = FN_TYPE;  off = a - A_TYPE;
                end else if (gpx_in_bank(a, A_BIAS)) begin
                    d.fn = FN_BIAS;  off = a - A_BIAS;
                end else if (gpx_in_bank(a, A_SET)) begin
                    d.fn = FN_SET;   off = a - A_SET;
                end else if (gpx_in_bank(a, A_CLR)) begin
                    d.fn = FN_CLR;   off = a - A_CLR;
                end
            end
        endcase
        d.grp = off[GSEL_W-1:0];
        return d;
    endfunction

    // byte of a per-pin vector that belongs to one group
    function automatic logic [GRP_W-1:0] gpx_pick(input logic [PIN_N-1:0] v,
                                                   input logic [GSEL_W-1:0] g);
        return GRP_W'(v >> (int'(g) * GRP_W));
    endfunction

endpackage

// File: rtl/gpx_bus_port.sv
module gpx_bus_port
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       first,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    output gpx_acc_t   acc
);
    logic [7:0] ptr_q;
    logic [7:0] eff;

    assign eff = first ? addr : ptr_q;

    // pointer steps past every byte touched, read or write
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (wr || rd) begin
            ptr_q <= eff + 8'd1;
        end
    end

    always_comb begin
        acc.wr   = wr;
        acc.rd   = rd && !wr;
        acc.dec  = gpx_decode(eff);
        acc.data = wdata;
    end
endmodule

// File: rtl/gpx_busy_timer.sv
module gpx_busy_timer #(
    parameter int CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int            CW   = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/gpx_in_sync.sv
module gpx_in_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] mask,
    output logic [W-1:0] state
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            sync_q  <= '0;
            state_q <= '0;
        end else begin
            meta_q  <= pins;
            sync_q  <= meta_q;
            state_q <= sync_q & mask;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/gpx_pin_bank.sv
module gpx_pin_bank
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  gpx_fn_e           fn,
    input  logic [GSEL_W-1:0] grp,
    input  logic [GRP_W-1:0]  data,
    output logic [PIN_N-1:0]  dir,
    output logic [PIN_N-1:0]  typ,
    output logic [PIN_N-1:0]  bias,
    output logic [PIN_N-1:0]  outv
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [GRP_W-1:0] dir_r, typ_r, bias_r, out_r;
        logic             hit;

        assign hit = wr_en && (grp == GSEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                dir_r  <= '0;
                typ_r  <= '0;
                bias_r <= '0;
                out_r  <= '0;
            end else if (hit) begin
                case (fn)
                    FN_DIR:  dir_r  <= data;
                    FN_TYPE: typ_r  <= data;
                    FN_BIAS: bias_r <= data;
                    FN_SET:  out_r  <= out_r | data;
                    FN_CLR:  out_r  <= out_r & ~data;
                    default: ;
                endcase
            end
        end

        assign dir [g*GRP_W +: GRP_W] = dir_r;
        assign typ [g*GRP_W +: GRP_W] = typ_r;
        assign bias[g*GRP_W +: GRP_W] = bias_r;
        assign outv[g*GRP_W +: GRP_W] = out_r;
    end
endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int         RST_CYCLES = 2_500_000,
    parameter logic [7:0] VER_MAJOR  = 8'h01,
    parameter logic [7:0] VER_MINOR  = 8'h00,
    parameter logic [6:0] ADDR7_BASE = 7'h42
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_strap,
    input  logic [7:0]       reg_addr,
    input  logic             reg_first,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [PIN_N-1:0] pin_in,
    output logic [PIN_N-1:0] pin_oe,
    output logic [PIN_N-1:0] pin_out,
    output logic [PIN_N-1:0] pin_pu,
    output logic [PIN_N-1:0] pin_pd,
    output logic             busy
);
    gpx_acc_t         acc;
    logic             wr_ok;
    logic             sys_hit;
    logic             soft_rst;
    logic             en_main_q, en_alt_q;
    logic [PIN_N-1:0] grp_en;
    logic [PIN_N-1:0] dir, typ, bias, outv, state;
    logic [7:0]       rd_val;
    logic [7:0]       rdata_q;
    logic [7:0]       ident;
    logic [7:0]       sys_val;

    gpx_bus_port u_port (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .first (reg_first),
        .wr    (reg_wr),
        .rd    (reg_rd),
        .wdata (reg_wdata),
        .acc   (acc)
    );

    assign wr_ok    = acc.wr && !busy;
    assign sys_hit  = wr_ok && (acc.dec.fn == FN_SYS);
    assign soft_rst = sys_hit && acc.data[SYS_RST_BIT];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            en_main_q <= 1'b0;
            en_alt_q  <= 1'b0;
        end else if (sys_hit) begin
            en_main_q <= acc.data[SYS_MAIN_BIT];
            en_alt_q  <= acc.data[SYS_ALT_BIT];
        end
    end

    gpx_busy_timer #(.CYCLES(RST_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (soft_rst),
        .busy  (busy)
    );

    gpx_pin_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .clear (soft_rst),
        .wr_en (wr_ok),
        .fn    (acc.dec.fn),
        .grp   (acc.dec.grp),
        .data  (acc.data),
        .dir   (dir),
        .typ   (typ),
        .bias  (bias),
        .outv  (outv)
    );

    // per-group enable fanned out to pins
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_en
        if (g < MAIN_GRP) begin : g_main
            assign grp_en[g*GRP_W +: GRP_W] = {GRP_W{en_main_q}};
        end else begin : g_alt
            assign grp_en[g*GRP_W +: GRP_W] = {GRP_W{en_alt_q}};
        end
    end

    gpx_in_sync #(.W(PIN_N)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pins  (pin_in),
        .mask  (grp_en),
        .state (state)
    );

    // pad drive: open-drain outputs only enable while pulling low
    assign pin_oe  = grp_en & dir & (~typ | ~outv);
    assign pin_out = grp_en & dir & ~typ & outv;
    assign pin_pu  = grp_en & ~dir & typ & bias;
    assign pin_pd  = grp_en & ~dir & typ & ~bias;

    assign ident = ~{ADDR7_BASE[6:1], ADDR7_BASE[0] | addr_strap, 1'b0};

    always_comb begin
        sys_val               = '0;
        sys_val[SYS_MAIN_BIT] = en_main_q;
        sys_val[SYS_ALT_BIT]  = en_alt_q;
    end

    always_comb begin
        case (acc.dec.fn)
            FN_IDENT: rd_val = ident;
            FN_VMAJ:  rd_val = VER_MAJOR;
            FN_VMIN:  rd_val = VER_MINOR;
            FN_SYS:   rd_val = sys_val;
            FN_STATE: rd_val = gpx_pick(state, acc.dec.grp);
            FN_DIR:   rd_val = gpx_pick(dir, acc.dec.grp);
            FN_TYPE:  rd_val = gpx_pick(typ, acc.dec.grp);
            FN_BIAS:  rd_val = gpx_pick(bias, acc.dec.grp);
            FN_SET,
            FN_CLR:   rd_val = gpx_pick(outv, acc.dec.grp);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (acc.rd) begin
            rdata_q <= rd_val;
        end
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             wr_rst_bit,
    input logic [7:0]       reg_rdata,
    input logic [PIN_N-1:0] pin_oe,
    input logic [PIN_N-1:0] pin_out,
    input logic [PIN_N-1:0] pin_pu,
    input logic [PIN_N-1:0] pin_pd,
    input logic             en_main,
    input logic             en_alt
);
    localparam int MAIN_W = MAIN_GRP * GRP_W;

    a_r11_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((pin_oe | pin_out | pin_pu | pin_pd) == '0));

    a_r11_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr && wr_rst_bit));

    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    a_r7_pull_safe: assert property (@(posedge clk) disable iff (rst)
        ((pin_pu & pin_pd) | (pin_oe & (pin_pu | pin_pd))) == '0);

    a_r5_out_needs_oe: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    a_r10_main_gate: assert property (@(posedge clk) disable iff (rst)
        !en_main |-> ((pin_oe[MAIN_W-1:0] | pin_pu[MAIN_W-1:0] | pin_pd[MAIN_W-1:0]) == '0));

    a_r10_alt_gate: assert property (@(posedge clk) disable iff (rst)
        !en_alt |-> ((pin_oe[PIN_N-1:MAIN_W] | pin_pu[PIN_N-1:MAIN_W] | pin_pd[PIN_N-1:MAIN_W]) == '0));
endmodule

bind gpx_core gpx_checker i_gpx_checker (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .wr_rst_bit (reg_wdata[7]),
    .reg_rdata  (reg_rdata),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .pin_pu     (pin_pu),
    .pin_pd     (pin_pd),
    .en_main    (en_main_q),
    .en_alt     (en_alt_q)
);

// File: tb/test_gpx_core.sv
`timescale 1ns/1ps
module test_gpx_core;
    localparam int         RST_N = 40;
    localparam logic [7:0] VMAJ  = 8'h03;
    localparam logic [7:0] VMIN  = 8'h2A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_strap = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_first = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_oe, pin_out, pin_pu, pin_pd;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpx_core #(.RST_CYCLES(RST_N), .VER_MAJOR(VMAJ), .VER_MINOR(VMIN)) i_gpx_core (
        .clk(clk), .rst(rst), .addr_strap(addr_strap), .reg_addr(reg_addr),
        .reg_first(reg_first), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu), .pin_pd(pin_pd),
        .busy(busy)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [23:0] m_dir, m_typ, m_bias, m_out, s1, s2, m_state;
    bit        m_main, m_alt;
    int        m_busy;
    bit [7:0]  m_rd, m_ptr;

    function automatic bit [7:0] m_read(input bit [7:0] a);
        bit [6:0] a7;
        a7 = 7'h42 | {6'b0, addr_strap};
        if (a == 8'h00) return ~{a7, 1'b0};
        if (a == 8'h01) return VMAJ;
        if (a == 8'h02) return VMIN;
        if (a == 8'h40) return {4'b0, m_alt, 2'b0, m_main};
        if (a >= 8'h10 && a <= 8'h12) return m_state[8*int'(a-8'h10) +: 8];
        if (a >= 8'h60 && a <= 8'h62) return m_dir[8*int'(a-8'h60) +: 8];
        if (a >= 8'h64 && a <= 8'h66) return m_typ[8*int'(a-8'h64) +: 8];
        if (a >= 8'h68 && a <= 8'h6A) return m_bias[8*int'(a-8'h68) +: 8];
        if (a >= 8'h6C && a <= 8'h6E) return m_out[8*int'(a-8'h6C) +: 8];
        if (a >= 8'h70 && a <= 8'h72) return m_out[8*int'(a-8'h70) +: 8];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        bit [7:0]  eff;
        bit [23:0] enm;
        bit        bsy;
        if (rst) begin
            m_dir = '0; m_typ = '0; m_bias = '0; m_out = '0;
            s1 = '0; s2 = '0; m_state = '0;
            m_main = 0; m_alt = 0; m_busy = 0; m_rd = '0; m_ptr = '0;
        end else begin
            eff = reg_first ? reg_addr : m_ptr;
            if (reg_wr || reg_rd) m_ptr = eff + 8'd1;
            if (reg_rd && !reg_wr) m_rd = m_read(eff);
            enm = {{8{m_alt}}, {16{m_main}}};
            m_state = s2 & enm;
            s2 = s1;
            s1 = pin_in;
            bsy = (m_busy != 0);
            if (m_busy > 0) m_busy--;
            if (reg_wr && !bsy) begin
                if (eff == 8'h40) begin
                    if (reg_wdata[7]) begin
                        m_dir = '0; m_typ = '0; m_bias = '0; m_out = '0;
                        m_main = 0; m_alt = 0; m_busy = RST_N;
                    end else begin
                        m_main = reg_wdata[0];
                        m_alt  = reg_wdata[3];
                    end
                end else if (eff >= 8'h60 && eff <= 8'h62) m_dir[8*int'(eff-8'h60) +: 8] = reg_wdata;
                else if (eff >= 8'h64 && eff <= 8'h66) m_typ[8*int'(eff-8'h64) +: 8] = reg_wdata;
                else if (eff >= 8'h68 && eff <= 8'h6A) m_bias[8*int'(eff-8'h68) +: 8] = reg_wdata;
                else if (eff >= 8'h6C && eff <= 8'h6E)
                    m_out[8*int'(eff-8'h6C) +: 8] = m_out[8*int'(eff-8'h6C) +: 8] | reg_wdata;
                else if (eff >= 8'h70 && eff <= 8'h72)
                    m_out[8*int'(eff-8'h70) +: 8] = m_out[8*int'(eff-8'h70) +: 8] & ~reg_wdata;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        bit [23:0] e_oe, e_out, e_pu, e_pd;
        bit        en;
        if (cmp_on && !rst) begin
            for (int n = 0; n < 24; n++) begin
                en = (n < 16) ? m_main : m_alt;
                e_oe[n]  = en & m_dir[n] & (!m_typ[n] | !m_out[n]);
                e_out[n] = en & m_dir[n] & !m_typ[n] & m_out[n];
                e_pu[n]  = en & !m_dir[n] & m_typ[n] & m_bias[n];
                e_pd[n]  = en & !m_dir[n] & m_typ[n] & !m_bias[n];
            end
            check("R5/R8/R10 model pin_oe", 32'(pin_oe), 32'(e_oe));
            check("R5/R8/R10 model pin_out", 32'(pin_out), 32'(e_out));
            check("R7/R10 model pin_pu", 32'(pin_pu), 32'(e_pu));
            check("R7/R10 model pin_pd", 32'(pin_pd), 32'(e_pd));
            check("R11 model busy", 32'(busy), 32'(m_busy != 0));
            check("R13 model reg_rdata", 32'(reg_rdata), 32'(m_rd));
        end
    end

    // ---------------- stimulus tasks (entered at a negedge) ----------------
    task automatic wr_b(input logic [7:0] a, input logic first, input logic [7:0] d);
        reg_addr = a; reg_first = first; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_first = 1'b0;
    endtask

    task automatic rd_b(input logic [7:0] a, input logic first, output logic [7:0] v);
        reg_addr = a; reg_first = first; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; reg_first = 1'b0;
        v = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2, v3;
        int         bcnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe after reset", 32'(pin_oe), 0);
        check("R1 pulls after reset", 32'(pin_pu | pin_pd), 0);
        check("R1 busy after reset", 32'(busy), 0);
        check("R1 rdata after reset", 32'(reg_rdata), 0);

        // R2 identity for both straps
        rd_b(8'h00, 1, v);  check("R2 ident strap0", 32'(v), 32'h7B);
        addr_strap = 1'b1;
        rd_b(8'h00, 1, v);  check("R2 ident strap1", 32'(v), 32'h79);
        addr_strap = 1'b0;

        // R3 version burst
        rd_b(8'h01, 1, v);
        rd_b(8'h00, 0, v2);
        check("R3 burst major", 32'(v), 32'(VMAJ));
        check("R3 burst minor", 32'(v2), 32'(VMIN));

        // R4 system control
        wr_b(8'h40, 1, 8'h09); rd_b(8'h40, 1, v); check("R4 sys both on", 32'(v), 32'h09);
        wr_b(8'h40, 1, 8'h76); rd_b(8'h40, 1, v); check("R4 sys other bits", 32'(v), 32'h00);
        wr_b(8'h40, 1, 8'h09);

        // R5 direction write burst and readback
        wr_b(8'h60, 1, 8'hA5); wr_b(8'h00, 0, 8'h0F); wr_b(8'h00, 0, 8'hF0);
        rd_b(8'h60, 1, v); rd_b(8'h00, 0, v2); rd_b(8'h00, 0, v3);
        check("R5 dir byte0", 32'(v), 32'hA5);
        check("R5 dir byte1", 32'(v2), 32'h0F);
        check("R5 dir byte2", 32'(v3), 32'hF0);
        check("R5 pin_oe map", 32'(pin_oe), 32'hF00FA5);

        // R6 set / clear masks
        wr_b(8'h6C, 1, 8'h81); rd_b(8'h6C, 1, v);
        check("R6 set readback", 32'(v), 32'h81);
        check("R6 pin_out after set", 32'(pin_out), 32'h000081);
        wr_b(8'h70, 1, 8'h01); rd_b(8'h70, 1, v);
        check("R6 clear keeps others", 32'(v), 32'h80);
        wr_b(8'h6E, 1, 8'hFF);
        check("R6 pin_out group2", 32'(pin_out), 32'hF00080);

        // R7 bias on inputs of group 1
        wr_b(8'h65, 1, 8'hF0); wr_b(8'h69, 1, 8'h30);
        check("R7 pull-up", 32'(pin_pu), 32'h003000);
        check("R7 pull-down", 32'(pin_pd), 32'h00C000);

        // R8 open drain on group 0 outputs (latch 0x80, dir 0xA5)
        wr_b(8'h64, 1, 8'h81); wr_b(8'h68, 1, 8'hFF);
        check("R8 open-drain oe", 32'(pin_oe[7:0]), 32'h25);
        check("R8 open-drain out", 32'(pin_out[7:0]), 32'h00);
        check("R7 no pull on push-pull inputs", 32'(pin_pu[7:0]), 32'h00);

        // R9 input state
        pin_in = 24'h5A3C96;
        repeat (3) @(negedge clk);
        rd_b(8'h10, 1, v); rd_b(8'h00, 0, v2); rd_b(8'h00, 0, v3);
        check("R9 state byte0", 32'(v), 32'h96);
        check("R9 state byte1", 32'(v2), 32'h3C);
        check("R9 state byte2", 32'(v3), 32'h5A);
        wr_b(8'h40, 1, 8'h01);
        repeat (2) @(negedge clk);
        rd_b(8'h12, 1, v); check("R9 disabled set reads 0", 32'(v), 32'h00);

        // R10 disabled alternate set
        check("R10 alt oe off", 32'(pin_oe[23:16]), 0);
        check("R10 alt out off", 32'(pin_out[23:16]), 0);

        // R12 unmapped and read-only
        rd_b(8'h20, 1, v); check("R12 unmapped read", 32'(v), 0);
        rd_b(8'h63, 1, v); check("R12 gap read", 32'(v), 0);
        wr_b(8'h10, 1, 8'hFF); rd_b(8'h10, 1, v);
        check("R12 state write ignored", 32'(v), 32'h96);
        wr_b(8'h63, 1, 8'hFF); wr_b(8'h00, 1, 8'h00);
        check("R12 gap write ignored", 32'(pin_oe), 32'h000F25);

        // R13 hold and simultaneous strobes
        repeat (3) @(negedge clk);
        check("R13 rdata holds", 32'(reg_rdata), 32'h96);
        reg_addr = 8'h61; reg_first = 1'b1; reg_wdata = 8'hFF; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_first = 1'b0;
        check("R13 write wins, no read", 32'(reg_rdata), 32'h96);
        rd_b(8'h61, 1, v); check("R13 write took place", 32'(v), 32'hFF);

        // R11 soft reset and busy window
        wr_b(8'h40, 1, 8'h89);
        bcnt = busy ? 1 : 0;
        check("R11 busy raised", 32'(busy), 1);
        check("R11 pins cleared", 32'(pin_oe | pin_out), 0);
        wr_b(8'h60, 1, 8'hFF); if (busy) bcnt++;
        rd_b(8'h60, 1, v);     if (busy) bcnt++;
        check("R11 write ignored while busy", 32'(v), 0);
        rd_b(8'h40, 1, v);     if (busy) bcnt++;
        check("R11 sys cleared, bit7 reads 0", 32'(v), 0);
        while (busy) begin
            @(negedge clk);
            if (busy) bcnt++;
        end
        check("R11 busy length", 32'(bcnt), 32'(RST_N));
        wr_b(8'h60, 1, 8'h3C); rd_b(8'h60, 1, v);
        check("R11 writes accepted after busy", 32'(v), 32'h3C);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule